// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a dot-product engine, such as the inner loop of a finite impulse response filter. On every cycle that carries a valid strobe it multiplies two signed two's complement operands at full precision and then clears, loads or adds into a wide accumulator. The accumulator has guard bits above the product width, so long runs of products do not wrap.

The accumulator is read through a separate output stage, which has three steps. It first shifts the value right arithmetically by a run-time amount. It then optionally rounds to nearest by adding the bit just below the kept LSB. Last, it clamps the result to the narrower output word. The unit can finish one multiply-accumulate per clock. The output word is valid on the cycle after each operation, and a sticky flag records that a clamp occurred.

Top module: `fxp_mac`

## Requirements
- R1: An operation with `op_sel` = 2'b01 (load) and `in_valid` high sets the accumulator to the exact signed product `a_in * b_in`, sign-extended to the accumulator width.
- R2: An operation with `op_sel` = 2'b10 (accumulate) and `in_valid` high adds the exact signed product to the accumulator. Back-to-back operations are accepted on every cycle, one per cycle, and the accumulator wraps modulo 2^ACC_W.
- R3: The accumulator is 2*OP_W + GUARD_W bits wide. A sum of 2^GUARD_W full-scale products (each (-2^(OP_W-1))^2) is held exactly.
- R4: `op_sel` = 2'b00 (clear) with `in_valid` high sets the accumulator to zero. `op_sel` = 2'b11 (hold) with `in_valid` high leaves it unchanged.
- R5: While `in_valid` is low, the accumulator keeps its value whatever `op_sel`, `a_in` and `b_in` carry.
- R6: `out_valid` is `in_valid` delayed by exactly one clock. `out_data` in that cycle reflects the accumulator after the operation.
- R7: `out_data` is derived from the accumulator shifted right arithmetically by `shift_amt`. Amounts above ACC_W-1 act as ACC_W-1.
- R8: When `round_en` is high and the shift amount is non-zero, the bit just below the kept LSB (accumulator bit shift-1) is added to the shifted value before saturation. When `round_en` is low, the shifted value is truncated.
- R9: A shifted and rounded value above 2^(OUT_W-1)-1 gives `out_data` = 2^(OUT_W-1)-1. A value below -2^(OUT_W-1) gives -2^(OUT_W-1). Values in range pass through unchanged.
- R10: `sat_flag` rises on the clock edge at which `out_valid` is high and the output clamps. It then stays high until a cycle with `sat_clr` high. `sat_clr` takes priority over a clamp at the same edge, and a clamp while `out_valid` is low does not set the flag.
- R11: After synchronous active-low reset, the accumulator is zero and `out_valid` and `sat_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 clear, 01 load, 10 accumulate, 11 hold |
| a_in | input | OP_W | Signed operand A |
| b_in | input | OP_W | Signed operand B |
| shift_amt | input | SH_W | Arithmetic right-shift amount for the output |
| round_en | input | 1 | Round-to-nearest enable |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_data | output | OUT_W | Scaled, rounded and saturated result |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The bench builds the unit with OP_W = 4, GUARD_W = 2 and OUT_W = 4, which gives a 10-bit accumulator and a 4-bit shift amount. At this size every operand pair can be loaded and checked in 256 cycles. Every shift amount, including the clamped ones above 9, can be tried with and without rounding. Four full-scale products already fill the guard bits, and most products overflow the 4-bit output, so the accumulator edge, both clamp rails and the sticky flag are all reached in a short run. A pseudo-random mix of operations, idle cycles and flag clears then follows, checked against an arithmetic model.

// File: rtl/fxp_mac_pkg.sv
// Shared types for the multiply-accumulate unit.
// Assumes: op_sel is a 2-bit field decoded exactly as listed below.
package fxp_mac_pkg;

    typedef enum logic [1:0] {
        MAC_CLEAR = 2'b00,
        MAC_LOAD  = 2'b01,
        MAC_ACCUM = 2'b10,
        MAC_HOLD  = 2'b11
    } mac_op_e;

endpackage

// File: rtl/fxp_mac_mul.sv
// Full-precision signed multiplier, purely combinational.
// Assumes: both operands are two's complement; the product is 2*OP_W bits,
// which holds every product exactly, including (-2^(OP_W-1))^2.
module fxp_mac_mul #(
    parameter int OP_W = 16,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic signed [OP_W-1:0]   a_in,
    input  logic signed [OP_W-1:0]   b_in,
    output logic signed [PROD_W-1:0] prod
);

    // Signed product at full width.
    always_comb begin
        prod = PROD_W'(a_in) * PROD_W'(b_in);
    end

endmodule

// File: rtl/fxp_mac_acc.sv
// Wide accumulator register with guard bits above the product width.
// Assumes: ACC_W > PROD_W; the product is sign-extended before use; one
// operation is taken per cycle in which in_valid is high.
module fxp_mac_acc
    import fxp_mac_pkg::*;
#(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40,
    localparam int GUARD_W = ACC_W - PROD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  mac_op_e                  op,
    input  logic signed [PROD_W-1:0] prod,
    output logic signed [ACC_W-1:0]  acc
);

    logic signed [ACC_W-1:0] prod_ext;

    // Sign-extend the product into the guard bits.
    always_comb begin
        prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};
    end

    // Accumulator update: clear, load, add or hold on a valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (in_valid) begin
            case (op)
                MAC_CLEAR: acc <= '0;
                MAC_LOAD:  acc <= prod_ext;
                MAC_ACCUM: acc <= acc + prod_ext;
                default:   acc <= acc;
            endcase
        end
    end

endmodule

// File: rtl/fxp_mac_scale.sv
// Output stage: arithmetic right shift, optional round-to-nearest, then
// saturation to OUT_W bits. Purely combinational.
// Assumes: OUT_W <= ACC_W; shift amounts above ACC_W-1 act as ACC_W-1.
module fxp_mac_scale #(
    parameter int ACC_W = 40,
    parameter int OUT_W = 16,
    parameter int SH_W  = 6,
    localparam int EXT_W = ACC_W + 1,
    localparam int HI_W  = EXT_W - OUT_W + 1
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [SH_W-1:0]         shift_amt,
    input  logic                    round_en,
    output logic [OUT_W-1:0]        out_data,
    output logic                    clamp
);

    localparam logic [SH_W-1:0] SH_MAX = SH_W'(ACC_W - 1);

    logic [SH_W-1:0]         sh;
    logic signed [ACC_W-1:0] pre;
    logic signed [ACC_W-1:0] shifted;
    logic                    rbit;
    logic signed [EXT_W-1:0] sum;
    logic                    in_range;

    // Limit the shift amount, then shift one less so the round bit is kept.
    always_comb begin
        sh = (shift_amt > SH_MAX) ? SH_MAX : shift_amt;
        if (sh == '0) begin
            pre     = acc;
            shifted = acc;
            rbit    = 1'b0;
        end else begin
            pre     = acc >>> (sh - SH_W'(1));
            shifted = pre >>> 1;
            rbit    = round_en & pre[0];
        end
    end

    // Round one bit wider than the accumulator, then clamp to the output range.
    always_comb begin
        sum      = {shifted[ACC_W-1], shifted} + {{ACC_W{1'b0}}, rbit};
        in_range = (sum[EXT_W-1:OUT_W-1] == '0) || (sum[EXT_W-1:OUT_W-1] == {HI_W{1'b1}});
        clamp    = !in_range;
        if (in_range) begin
            out_data = sum[OUT_W-1:0];
        end else if (sum[EXT_W-1]) begin
            out_data = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            out_data = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end

endmodule

// File: rtl/fxp_mac.sv
// Fixed-point multiply-accumulate unit, top level.
// Multiplies two signed operands, clears, loads or accumulates the product
// into a guarded accumulator, and reads the accumulator out through a
// shift / round / saturate stage with a sticky saturation flag.
// Assumes: synchronous active-low reset; OUT_W <= 2*OP_W + GUARD_W.
module fxp_mac
    import fxp_mac_pkg::*;
#(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8,
    parameter int OUT_W   = 16,
    parameter int SH_W    = $clog2(2 * OP_W + GUARD_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             op_sel,
    input  logic signed [OP_W-1:0] a_in,
    input  logic signed [OP_W-1:0] b_in,
    input  logic [SH_W-1:0]        shift_amt,
    input  logic                   round_en,
    input  logic                   sat_clr,
    output logic [OUT_W-1:0]       out_data,
    output logic                   out_valid,
    output logic                   sat_flag
);

    localparam int PROD_W = 2 * OP_W;
    localparam int ACC_W  = PROD_W + GUARD_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc;
    logic                     clamp;

    fxp_mac_mul #(.OP_W(OP_W)) u_mul (
        .a_in (a_in),
        .b_in (b_in),
        .prod (prod)
    );

    fxp_mac_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op       (mac_op_e'(op_sel)),
        .prod     (prod),
        .acc      (acc)
    );

    fxp_mac_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
        .acc       (acc),
        .shift_amt (shift_amt),
        .round_en  (round_en),
        .out_data  (out_data),
        .clamp     (clamp)
    );

    // Result qualifier: one cycle behind the operation strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Sticky saturation flag; an explicit clear wins over a new clamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_flag <= 1'b0;
        end else if (sat_clr) begin
            sat_flag <= 1'b0;
        end else if (out_valid && clamp) begin
            sat_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/fxp_mac_chk.sv
// Property checker for fxp_mac, observing only its ports.
// Assumes: bound to every fxp_mac instance through the bind below.
module fxp_mac_chk #(
    parameter int OUT_W = 16,
    parameter int SH_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op_sel,
    input logic [SH_W-1:0]  shift_amt,
    input logic             round_en,
    input logic             sat_clr,
    input logic [OUT_W-1:0] out_data,
    input logic             out_valid,
    input logic             sat_flag
);

    localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b00) |=> (out_data == '0));

    p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || op_sel == 2'b11) ##1 ($stable(shift_amt) && $stable(round_en))
        |-> $stable(out_data));

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag);

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sat_clr |=> !sat_flag);

    p_flag_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(out_valid));

    p_clamp_rail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> ($past(out_data) == OUT_MAX || $past(out_data) == OUT_MIN));

endmodule

bind fxp_mac fxp_mac_chk #(.OUT_W(OUT_W), .SH_W(SH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .shift_amt (shift_amt),
    .round_en  (round_en),
    .sat_clr   (sat_clr),
    .out_data  (out_data),
    .out_valid (out_valid),
    .sat_flag  (sat_flag)
);

// File: tb/fxp_mac_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for fxp_mac built small (4-bit operands, 2 guard bits,
// 4-bit output) so operand pairs and shift amounts can be swept exhaustively.
module fxp_mac_tb_top;

    localparam int TB_OP_W  = 4;
    localparam int TB_GRD_W = 2;
    localparam int TB_OUT_W = 4;
    localparam int TB_ACC_W = 2 * TB_OP_W + TB_GRD_W;
    localparam int TB_SH_W  = $clog2(TB_ACC_W);
    localparam longint OMAX = (64'sd1 <<< (TB_OUT_W - 1)) - 1;
    localparam longint OMIN = -(64'sd1 <<< (TB_OUT_W - 1));

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      in_valid = 1'b0;
    logic [1:0]                op_sel = 2'b00;
    logic signed [TB_OP_W-1:0] a_in = '0;
    logic signed [TB_OP_W-1:0] b_in = '0;
    logic [TB_SH_W-1:0]        shift_amt = '0;
    logic                      round_en = 1'b0;
    logic                      sat_clr = 1'b0;
    logic signed [TB_OUT_W-1:0] out_data;
    logic                      out_valid;
    logic                      sat_flag;

    int checks = 0;
    int errors = 0;

    longint m_acc  = 0;
    bit     m_ov   = 1'b0;
    bit     m_flag = 1'b0;

    always #5 clk = ~clk;

    fxp_mac #(.OP_W(TB_OP_W), .GUARD_W(TB_GRD_W), .OUT_W(TB_OUT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .a_in      (a_in),
        .b_in      (b_in),
        .shift_amt (shift_amt),
        .round_en  (round_en),
        .sat_clr   (sat_clr),
        .out_data  (out_data),
        .out_valid (out_valid),
        .sat_flag  (sat_flag)
    );

    // Reduce a value modulo 2^ACC_W as a signed number.
    function automatic longint wrap_acc(longint x);
        logic signed [TB_ACC_W-1:0] t;
        t = x[TB_ACC_W-1:0];
        return longint'(t);
    endfunction

    // Shift and round per the requirements, before saturation.
    function automatic longint scaled(longint acc, int sh, bit rnd);
        int s;
        longint v;
        s = (sh > TB_ACC_W - 1) ? TB_ACC_W - 1 : sh;
        v = acc >>> s;
        if (rnd && s > 0) v = v + ((acc >>> (s - 1)) & 64'sd1);
        return v;
    endfunction

    function automatic longint sat(longint v);
        return (v > OMAX) ? OMAX : ((v < OMIN) ? OMIN : v);
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One operation: drive at the falling edge, update the model at the
    // rising edge, check at the next falling edge.
    task automatic step(bit v, bit [1:0] op, int av, int bv, int sh, bit rnd,
                        bit clr, string tag);
        longint pre;
        bit     clamp_pre;
        in_valid  = v;
        op_sel    = op;
        a_in      = TB_OP_W'(av);
        b_in      = TB_OP_W'(bv);
        shift_amt = TB_SH_W'(sh);
        round_en  = rnd;
        sat_clr   = clr;
        pre       = scaled(m_acc, sh, rnd);
        clamp_pre = (sat(pre) != pre);
        @(posedge clk);
        if (clr) m_flag = 1'b0;
        else if (m_ov && clamp_pre) m_flag = 1'b1;
        if (v) begin
            case (op)
                2'b00:   m_acc = 0;
                2'b01:   m_acc = wrap_acc(longint'(av) * longint'(bv));
                2'b10:   m_acc = wrap_acc(m_acc + longint'(av) * longint'(bv));
                default: m_acc = m_acc;
            endcase
        end
        m_ov = v;
        @(negedge clk);
        check("R6", "out_valid", longint'(out_valid), longint'(m_ov));
        check("R10", "sat_flag", longint'(sat_flag), longint'(m_flag));
        check(tag, "out_data", longint'(out_data), sat(scaled(m_acc, sh, rnd)));
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check("R11", "out_valid", longint'(out_valid), 0);
        check("R11", "sat_flag", longint'(sat_flag), 0);
        check("R11", "out_data", longint'(out_data), 0);

        // R1: every operand pair loaded, with varied shift and rounding
        for (int i = -8; i < 8; i++) begin
            for (int j = -8; j < 8; j++) begin
                step(1'b1, 2'b01, i, j, (i + j) & 15, j[0], 1'b0, "R1");
            end
        end

        // R7 / R8: every shift amount on a negative accumulator value
        step(1'b1, 2'b01, 7, -7, 0, 1'b0, 1'b1, "R1");
        for (int s = 0; s < 16; s++) step(1'b1, 2'b11, 0, 0, s, 1'b0, 1'b0, "R7");
        for (int s = 0; s < 16; s++) step(1'b1, 2'b11, 0, 0, s, 1'b1, 1'b0, "R8");
        step(1'b1, 2'b01, 3, 5, 0, 1'b0, 1'b0, "R1");
        for (int s = 0; s < 16; s++) step(1'b1, 2'b11, 0, 0, s, 1'b1, 1'b0, "R8");

        // R3: four full-scale products fill the guard bits exactly (256)
        step(1'b1, 2'b00, 0, 0, 6, 1'b0, 1'b0, "R4");
        step(1'b1, 2'b01, -8, -8, 6, 1'b0, 1'b0, "R3");
        for (int k = 0; k < 3; k++) step(1'b1, 2'b10, -8, -8, 6, 1'b0, 1'b0, "R3");
        step(1'b1, 2'b11, 0, 0, 6, 1'b0, 1'b0, "R3");
        step(1'b1, 2'b11, 0, 0, 8, 1'b0, 1'b0, "R3");

        // R4: clear gives zero, hold keeps the value
        step(1'b1, 2'b00, 7, 7, 0, 1'b0, 1'b0, "R4");
        step(1'b1, 2'b01, 2, 3, 0, 1'b0, 1'b0, "R1");
        step(1'b1, 2'b11, 7, 7, 0, 1'b0, 1'b0, "R4");

        // R5: idle cycles ignore op and operands
        step(1'b0, 2'b01, 7, 7, 0, 1'b0, 1'b0, "R5");
        step(1'b0, 2'b00, 1, 1, 0, 1'b0, 1'b0, "R5");

        // R9: both rails
        step(1'b1, 2'b01, 7, 7, 0, 1'b0, 1'b1, "R9");
        step(1'b1, 2'b01, -8, 7, 0, 1'b0, 1'b0, "R9");
        // R10: clear beats a clamp at the same edge; idle clamp does not set
        step(1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b1, "R10");
        step(1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b0, "R10");
        step(1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b0, "R10");

        // R2: pseudo-random mix of operations, idles and flag clears
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2] | lfsr[3], lfsr[1:0],
                 int'($signed(lfsr[7:4])), int'($signed(lfsr[11:8])),
                 int'(lfsr[15:12]), lfsr[5], lfsr[14:12] == 3'b000, "R2");
        end
        // R2: a run of back-to-back accumulates
        step(1'b1, 2'b01, 3, 3, 0, 1'b0, 1'b0, "R2");
        for (int k = 0; k < 6; k++) step(1'b1, 2'b10, -2, 5, 2, 1'b1, 1'b0, "R2");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule